// File: doc/BRIEF.md
# Paged Memory Write Protection Unit

This block sits between a bus master and physical memory and checks every write against a per-page protect map. The address space is 1M words, so the physical address is 20 bits wide. It is cut into 1K-word pages, which gives 1024 pages. The unit keeps two independent protect maps. A write from the processor is checked against the processor map, and a write from a DMA engine is checked against the DMA map. A page whose bit is set in the map of the active master cannot be written by that master.

The address space is also divided into 64K-word blocks, and a programmable mask records which blocks have memory behind them. A write to a block marked absent is treated as a violation in the same way as a write to a protected page.

On a violation the downstream write enable stays low in that same cycle, so memory is left unchanged. A sticky error flag is raised toward the processor on the next clock edge. Software clears the flag with a clear strobe. Software sets or clears single page bits through a load port, and it rewrites the block mask as a whole word.

Top module: `page_wprot`

## Requirements
- R1: After reset the error flag is 0, every bit of both protect maps is 0 (every page is writable) and every block is marked present, so each write request produces an active write enable.
- R2: A write with `wr_dma`=0 is checked against the processor map at page index `wr_addr[19:10]`. If that bit is 1, `mem_we` stays 0 in the same cycle.
- R3: A write with `wr_dma`=1 is checked only against the DMA map. A bit set in one map has no effect on writes from the other master.
- R4: A load cycle (`ld_en`=1) writes `ld_val` into bit `ld_page` of the map chosen by `ld_sel` (0 selects the processor map, 1 selects the DMA map). No other bit of either map changes. The new value takes effect from the next cycle, so a write in the same cycle as the load sees the old value.
- R5: The block index is `wr_addr[19:16]`. A write to a block whose mask bit is 0 gets `mem_we`=0, whatever the page bits hold.
- R6: The error flag becomes 1 on the clock edge that ends a blocked write. It then stays 1 until a cycle with `err_clr`=1 and no new violation. A violation in the same cycle as `err_clr` leaves the flag at 1.
- R7: `mem_we` is never 1 while `wr_req` is 0. A cycle with `wr_req`=0 never sets the error flag, even when its address points at a protected page.
- R8: A cycle with `impl_wr`=1 loads `impl_din` into the block mask, where bit k set to 1 means block k is present. The new mask takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_req | input | 1 | Write strobe for the current bus cycle |
| wr_addr | input | 20 | Physical word address of the write |
| wr_dma | input | 1 | Master type: 0 processor, 1 DMA |
| mem_we | output | 1 | Write enable passed on to memory, low when the write is blocked |
| err_flag | output | 1 | Sticky protection error flag |
| err_clr | input | 1 | Clears the error flag |
| ld_en | input | 1 | Map load strobe |
| ld_sel | input | 1 | Map select: 0 processor, 1 DMA |
| ld_page | input | 10 | Page index to load |
| ld_val | input | 1 | Protect bit value to load |
| impl_wr | input | 1 | Block mask load strobe |
| impl_din | input | 16 | New block-present mask |

## Verification
The cases that are hardest to bring about from the ports are the ones where two things happen in the same cycle. One is a map load and a write that target the same page. The other is a clear strobe that arrives together with a new violation. Random stimulus seldom hits either, because the page space is large. So the random phase draws its addresses from a small pool of eight pages, mixed with random offsets, and issues loads, writes and clears often enough that such collisions happen many times. Directed steps also force each collision once: the same-page load and write, the set-and-clear, and the edge pages 0 and 1023.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;
   typedef enum logic {
      MASTER_CPU = 1'b0,
      MASTER_DMA = 1'b1
   } master_e;
   localparam int N_MASTERS = 2;
endpackage

// File: rtl/wp_prot_map.sv
`timescale 1ns/1ps
module wp_prot_map #(
   parameter int PG_W = 10,
   localparam int N_PAGES = 1 << PG_W
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_en,
   input  logic [PG_W-1:0] ld_page,
   input  logic            ld_val,
   input  logic [PG_W-1:0] rd_page,
   output logic            rd_bit
);
   logic [N_PAGES-1:0] bits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bits_q <= '0;
      else if (ld_en) bits_q[ld_page] <= ld_val;
   end

   assign rd_bit = bits_q[rd_page];

   // R4: a load touches at most one bit and lands the loaded value
   a_r4_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> ($countones(bits_q ^ $past(bits_q)) <= 1));
   a_r4_value_lands: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> (bits_q[$past(ld_page)] == $past(ld_val)));
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> $stable(bits_q));
endmodule

// File: rtl/wp_blk_guard.sv
`timescale 1ns/1ps
module wp_blk_guard #(
   parameter int BK_W = 4,
   parameter bit IMPL_CHECK = 1'b1,
   localparam int N_BLKS = 1 << BK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              impl_wr,
   input  logic [N_BLKS-1:0] impl_din,
   input  logic [BK_W-1:0]   rd_blk,
   output logic              blk_ok
);
   generate
      if (IMPL_CHECK) begin : g_mask
         logic [N_BLKS-1:0] mask_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       mask_q <= '1;
            else if (impl_wr) mask_q <= impl_din;
         end
         assign blk_ok = mask_q[rd_blk];

         // R8: mask load takes the input word; otherwise the mask holds
         a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
            impl_wr |=> (mask_q == $past(impl_din)));
         a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !impl_wr |=> $stable(mask_q));
      end else begin : g_open
         logic unused_blk;
         assign unused_blk = ^{clk, rst_n, impl_wr, impl_din, rd_blk};
         assign blk_ok = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/page_wprot.sv
`timescale 1ns/1ps
module page_wprot #(
   parameter int ADDR_W     = 20,
   parameter int PAGE_OFF_W = 10,
   parameter int BLK_OFF_W  = 16,
   parameter bit IMPL_CHECK = 1'b1,
   localparam int PG_W   = ADDR_W - PAGE_OFF_W,
   localparam int BK_W   = ADDR_W - BLK_OFF_W,
   localparam int N_BLKS = 1 << BK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_dma,
   output logic              mem_we,
   output logic              err_flag,
   input  logic              err_clr,
   input  logic              ld_en,
   input  logic              ld_sel,
   input  logic [PG_W-1:0]   ld_page,
   input  logic              ld_val,
   input  logic              impl_wr,
   input  logic [N_BLKS-1:0] impl_din
);
   import wp_pkg::*;

   // elaboration-time parameter checks
   generate
      if (ADDR_W <= PAGE_OFF_W) begin : g_bad_addr
         $error("page_wprot: ADDR_W must exceed PAGE_OFF_W");
      end
      if (BLK_OFF_W < PAGE_OFF_W || BLK_OFF_W >= ADDR_W) begin : g_bad_blk
         $error("page_wprot: block offset must lie between page offset and ADDR_W");
      end
      if (PG_W > 12) begin : g_bad_size
         $error("page_wprot: map larger than 4096 bits per master");
      end
   endgenerate

   logic [PG_W-1:0]      pg_idx;
   logic [BK_W-1:0]      bk_idx;
   logic [N_MASTERS-1:0] map_hit;
   logic                 page_hit;
   logic                 blk_ok;
   logic                 viol;
   logic                 unused_offset;

   assign pg_idx        = wr_addr[ADDR_W-1 -: PG_W];
   assign bk_idx        = wr_addr[ADDR_W-1 -: BK_W];
   assign unused_offset = ^wr_addr[PAGE_OFF_W-1:0];

   genvar m;
   generate
      for (m = 0; m < N_MASTERS; m++) begin : g_map
         wp_prot_map #(.PG_W(PG_W)) u_map (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld_en   (ld_en && (ld_sel == 1'(m))),
            .ld_page (ld_page),
            .ld_val  (ld_val),
            .rd_page (pg_idx),
            .rd_bit  (map_hit[m])
         );
      end
   endgenerate

   assign page_hit = (master_e'(wr_dma) == MASTER_DMA) ? map_hit[1] : map_hit[0];

   wp_blk_guard #(.BK_W(BK_W), .IMPL_CHECK(IMPL_CHECK)) u_blk (
      .clk      (clk),
      .rst_n    (rst_n),
      .impl_wr  (impl_wr),
      .impl_din (impl_din),
      .rd_blk   (bk_idx),
      .blk_ok   (blk_ok)
   );

   assign viol   = wr_req && (page_hit || !blk_ok);
   assign mem_we = wr_req && !viol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       err_flag <= 1'b0;
      else if (viol)    err_flag <= 1'b1;
      else if (err_clr) err_flag <= 1'b0;
   end

   // R2/R3: a hit in the active master's map suppresses the write
   a_r2_page_block: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && page_hit) |-> !mem_we);
   // R5: absent block suppresses the write
   a_r5_blk_block: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !blk_ok) |-> !mem_we);
   // R7: no enable without a request
   a_r7_we_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wr_req);
   // R6: flag sets after a violation, sticks without clear, rises only on violation
   a_r6_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> err_flag);
   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag);
   a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(viol));
endmodule

// File: tb/sim_page_wprot.sv
`timescale 1ns/1ps
module sim_page_wprot;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_req, wr_dma, err_clr, ld_en, ld_sel, ld_val, impl_wr;
   logic [19:0] wr_addr;
   logic [9:0]  ld_page;
   logic [15:0] impl_din;
   logic        mem_we, err_flag;

   always #10 clk = ~clk;

   page_wprot u0 (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_dma(wr_dma), .mem_we(mem_we), .err_flag(err_flag),
      .err_clr(err_clr), .ld_en(ld_en), .ld_sel(ld_sel),
      .ld_page(ld_page), .ld_val(ld_val), .impl_wr(impl_wr),
      .impl_din(impl_din)
   );

   int  nchk = 0;
   int  nfail = 0;
   bit  done = 0;
   bit  cpu_m [1024];
   bit  dma_m [1024];
   logic [15:0] impl_m;
   bit  err_m;

   function automatic bit exp_viol(bit req, logic [19:0] a, bit dma);
      if (!req) return 1'b0;
      if (!impl_m[a[19:16]]) return 1'b1;
      return dma ? dma_m[a[19:10]] : cpu_m[a[19:10]];
   endfunction

   task automatic check(string tag, logic act, logic exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(bit req, logic [19:0] a, bit dma, bit le, bit ls,
                       logic [9:0] lp, bit lv, bit iw, logic [15:0] id,
                       bit clr, string tag);
      bit    ev;
      string t;
      @(negedge clk);
      wr_req = req; wr_addr = a; wr_dma = dma; ld_en = le; ld_sel = ls;
      ld_page = lp; ld_val = lv; impl_wr = iw; impl_din = id; err_clr = clr;
      #2;
      ev = exp_viol(req, a, dma);
      t = tag;
      if (t == "") begin
         if (!req)                t = "R7";
         else if (!impl_m[a[19:16]]) t = "R5";
         else if (dma)            t = "R3";
         else                     t = "R2";
      end
      check(t, mem_we, req && !ev);
      @(posedge clk);
      err_m = ev | (err_m & !clr);
      if (le) begin
         if (ls) dma_m[lp] = lv; else cpu_m[lp] = lv;
      end
      if (iw) impl_m = id;
      #1;
      check("R6", err_flag, err_m);
   endtask

   task automatic wr(logic [19:0] a, bit dma, string tag);
      step(1, a, dma, 0, 0, 0, 0, 0, 16'h0, 0, tag);
   endtask
   task automatic ld(bit sel, logic [9:0] pg, bit v);
      step(0, 20'h0, 0, 1, sel, pg, v, 0, 16'h0, 0, "R7");
   endtask
   task automatic clr_err();
      step(0, 20'h0, 0, 0, 0, 0, 0, 0, 16'h0, 1, "R7");
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      impl_m = 16'hFFFF; err_m = 0;
      rst_n = 0; wr_req = 0; wr_addr = 0; wr_dma = 0; err_clr = 0;
      ld_en = 0; ld_sel = 0; ld_page = 0; ld_val = 0; impl_wr = 0; impl_din = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      #1 check("R1", err_flag, 1'b0);
      wr(20'h00000, 0, "R1");
      wr(20'hFFFFF, 1, "R1");
      wr(20'h8A3C1, 0, "R1");

      // R2 / R3: processor map bit only affects processor writes
      ld(0, 10'd5, 1);
      wr({10'd5, 10'h3FF}, 0, "R2");
      wr({10'd5, 10'h000}, 1, "R3");
      clr_err();
      ld(1, 10'd1023, 1);
      wr({10'd1023, 10'h155}, 1, "R3");
      wr({10'd1023, 10'h155}, 0, "R3");
      ld(1, 10'd0, 1);
      wr(20'h00010, 1, "R3");
      wr(20'h00010, 0, "R3");
      clr_err();

      // R4: same-cycle load sees old value; neighbours untouched; clear works
      step(1, {10'd7, 10'h0AA}, 0, 1, 0, 10'd7, 1, 0, 16'h0, 0, "R4");
      wr({10'd7, 10'h0AA}, 0, "R4");
      wr({10'd6, 10'h0AA}, 0, "R4");
      wr({10'd8, 10'h0AA}, 0, "R4");
      wr({10'd7, 10'h0AA}, 1, "R4");
      ld(0, 10'd7, 0);
      wr({10'd7, 10'h0AA}, 0, "R4");

      // R7: no request to a protected page
      clr_err();
      step(0, {10'd5, 10'h0}, 0, 0, 0, 0, 0, 0, 16'h0, 0, "R7");

      // R6: violation with clear in the same cycle keeps the flag
      step(1, {10'd5, 10'h0}, 0, 0, 0, 0, 0, 0, 16'h0, 1, "R6");
      step(0, 20'h0, 0, 0, 0, 0, 0, 0, 16'h0, 0, "R6");
      clr_err();

      // R8 / R5: block mask load and absent block
      step(1, 20'h00400, 0, 0, 0, 0, 0, 1, 16'hFFFE, 0, "R8");
      wr(20'h00400, 0, "R5");
      wr(20'h10400, 1, "R5");
      wr(20'h0F000, 1, "R5");
      step(0, 20'h0, 0, 0, 0, 0, 0, 1, 16'hFFFF, 1, "R8");
      wr(20'h00400, 0, "R8");

      // random phase over a small page pool
      for (int i = 0; i < 4000; i++) begin
         int k;
         logic [9:0] pg, lpg;
         logic [15:0] id;
         bit iw;
         k   = $urandom_range(0, 7);
         pg  = 10'((k * 131) ^ (k << 7));
         k   = $urandom_range(0, 7);
         lpg = 10'((k * 131) ^ (k << 7));
         iw  = ($urandom_range(0, 15) == 0);
         id  = ($urandom_range(0, 3) == 0) ? 16'hFFFF
                                            : 16'hFFFF ^ (16'h1 << $urandom_range(0, 15));
         step($urandom_range(0, 3) != 0, {pg, 10'($urandom)}, 1'($urandom),
              $urandom_range(0, 2) == 0, 1'($urandom), lpg, 1'($urandom),
              iw, id, $urandom_range(0, 7) == 0, "");
      end
      summary();
   end
endmodule